// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It combines two component predictors. The first is a table of 3-bit saturating counters selected by bits of the fetch program counter. The second is a table of 2-bit saturating counters selected by a global history of recent branch outcomes. A third table of 2-bit counters, also selected by that history, decides which of the two components supplies the final answer. The lookup is purely combinational, so the guess is ready in the same cycle as the instruction cache access that it runs beside.

Every guess comes with a metadata word. The fetch unit keeps this word with the branch and returns it on the update port once the branch resolves. From the metadata the block recomputes the indices used at prediction time and trains all three tables. The global history is advanced speculatively with each guess. When a resolved branch shows a mispredict, the history is rebuilt from the checkpoint held in the metadata, with the true outcome appended.

Top module: `tournament_predictor`

## Requirements
- R1: While reset is held, and afterwards until the first update, every PC-table counter is 3 (not taken), every path-table counter is 1 (not taken), every chooser counter is 1 (selects the PC table), and the history is zero. So the first lookup returns pred_taken = 0 and pred_meta = 0.
- R2: The PC table holds 2^L_IDX_W counters, each 3 bits wide, indexed by the PC word bits. A counter predicts taken when its value is 4 or more. An update moves it by one toward the outcome and saturates at 0 and 7.
- R3: The path table holds 2^H_W counters, each 2 bits wide, indexed by the history. A counter predicts taken when its value is 2 or more. An update moves it by one and saturates at 0 and 3.
- R4: pred_taken equals the path-table prediction when the chooser counter at the current history is 2 or more. Otherwise it equals the PC-table prediction.
- R5: A chooser counter changes only on an update whose metadata shows the two components disagreeing. It then moves by one toward the path table if the path table was correct, and toward the PC table otherwise.
- R6: On an accepted lookup (pred_valid = 1) with no repair in the same cycle, the history shifts left by one at the next edge. The final prediction enters at bit 0.
- R7: An update whose metadata bit 2 differs from upd_taken is a mispredict. At the next edge the history becomes {metadata history[H_W-2:0], upd_taken}. This repair takes priority over a lookup in the same cycle.
- R8: When there is neither an accepted lookup nor a repair, the history holds its value. A correctly predicted update leaves it unchanged.
- R9: pred_meta bit 0 is the PC-table prediction, bit 1 is the path-table prediction, bit 2 is the final prediction, and bits H_W+2:3 are the history used for the lookup.
- R10: An update trains the path table and the chooser at the history carried in upd_meta bits H_W+2:3, not at the current history. It trains the PC table at upd_pcw.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pred_valid | input | 1 | Lookup accepted; advances the history |
| pred_pcw | input | L_IDX_W | Fetch PC word-address bits used as the PC-table index |
| pred_taken | output | 1 | Final direction guess |
| pred_meta | output | H_W+3 | Metadata to keep with the branch |
| upd_valid | input | 1 | Resolved branch present |
| upd_pcw | input | L_IDX_W | PC word-address bits of the resolved branch |
| upd_taken | input | 1 | Resolved direction |
| upd_meta | input | H_W+3 | Metadata returned from the lookup |

## Verification
pred_taken and pred_meta are combinational. The bench reads them 1 ns after it drives pred_pcw, which is well before the next rising edge. A history shift or repair lands on the edge that samples the strobe, so the new history is read from pred_meta in the following cycle. A table write lands on the edge that samples upd_valid, so its effect is read by a lookup made after that edge. A reference model in the bench, built from the requirements, is advanced at those same edges. Every lookup is compared with the model, and directed sequences pin down saturation, chooser motion and the priority of repair over a lookup.

// File: rtl/tbp_pkg.sv
`timescale 1ns/1ps
package tbp_pkg;

  // One training step of a saturating counter of width w (w <= 8).
  function automatic logic [7:0] ctr_step(input logic [7:0] v, input logic up,
                                          input int unsigned w);
    logic [7:0] top;
    top = 8'((1 << w) - 1);
    if (up) return (v == top) ? v : v + 8'd1;
    else    return (v == 8'd0) ? v : v - 8'd1;
  endfunction

  // A counter says "taken" (or "pick second source") in its upper half.
  function automatic logic ctr_high(input logic [7:0] v, input int unsigned w);
    return v >= 8'(1 << (w - 1));
  endfunction

  // Reset value: one below the midpoint (weak low side).
  function automatic logic [7:0] ctr_weak_low(input int unsigned w);
    return 8'((1 << (w - 1)) - 1);
  endfunction

endpackage

// File: rtl/tbp_counter_table.sv
`timescale 1ns/1ps
module tbp_counter_table #(
  parameter int unsigned IDX_W = 10,
  parameter int unsigned CTR_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CTR_W-1:0] rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_up,
  output logic [CTR_W-1:0] wr_old,
  output logic [CTR_W-1:0] wr_new
);
  localparam int unsigned DEPTH = 1 << IDX_W;
  localparam logic [CTR_W-1:0] INIT = CTR_W'(tbp_pkg::ctr_weak_low(CTR_W));

  logic [CTR_W-1:0] mem [DEPTH];

  assign rd_ctr = mem[rd_idx];
  assign wr_old = mem[wr_idx];
  assign wr_new = CTR_W'(tbp_pkg::ctr_step(8'(wr_old), wr_up, CTR_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= INIT;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_new;
    end
  end
endmodule

// File: rtl/tbp_history.sv
`timescale 1ns/1ps
module tbp_history #(
  parameter int unsigned H_W = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           spec_en,
  input  logic           spec_bit,
  input  logic           fix_en,
  input  logic [H_W-1:0] fix_base,
  input  logic           fix_bit,
  output logic [H_W-1:0] hist
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hist <= '0;
    else if (fix_en)  hist <= {fix_base[H_W-2:0], fix_bit};
    else if (spec_en) hist <= {hist[H_W-2:0], spec_bit};
  end
endmodule

// File: rtl/tournament_predictor.sv
`timescale 1ns/1ps
module tournament_predictor #(
  parameter int unsigned L_IDX_W = 10,
  parameter int unsigned L_CTR_W = 3,
  parameter int unsigned H_W     = 12,
  parameter int unsigned G_CTR_W = 2,
  parameter int unsigned C_CTR_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pred_valid,
  input  logic [L_IDX_W-1:0] pred_pcw,
  output logic               pred_taken,
  output logic [H_W+2:0]     pred_meta,
  input  logic               upd_valid,
  input  logic [L_IDX_W-1:0] upd_pcw,
  input  logic               upd_taken,
  input  logic [H_W+2:0]     upd_meta
);
  localparam int unsigned M_LOC = 0;
  localparam int unsigned M_PTH = 1;
  localparam int unsigned M_FIN = 2;
  localparam int unsigned M_HLO = 3;

  logic [H_W-1:0]     hist_q;
  logic [L_CTR_W-1:0] lt_rd, lt_old, lt_new;
  logic [G_CTR_W-1:0] gt_rd, gt_old, gt_new;
  logic [C_CTR_W-1:0] ch_rd, ch_old, ch_new;
  logic               l_pred, g_pred, use_path;
  logic               lt_we, gt_we, ch_we, ch_up, repair_ev;
  logic [H_W-1:0]     u_hist;
  logic               u_loc, u_pth, u_fin;

  // metadata fields of the resolved branch
  assign u_hist = upd_meta[H_W+M_HLO-1:M_HLO];
  assign u_loc  = upd_meta[M_LOC];
  assign u_pth  = upd_meta[M_PTH];
  assign u_fin  = upd_meta[M_FIN];

  // training events, brought out by name for the checker
  assign lt_we     = upd_valid;
  assign gt_we     = upd_valid;
  assign ch_we     = upd_valid && (u_loc != u_pth);
  assign ch_up     = (u_pth == upd_taken);
  assign repair_ev = upd_valid && (u_fin != upd_taken);

  tbp_counter_table #(.IDX_W(L_IDX_W), .CTR_W(L_CTR_W)) u_pc_tbl (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(pred_pcw), .rd_ctr(lt_rd),
    .wr_en(lt_we), .wr_idx(upd_pcw), .wr_up(upd_taken),
    .wr_old(lt_old), .wr_new(lt_new)
  );

  tbp_counter_table #(.IDX_W(H_W), .CTR_W(G_CTR_W)) u_path_tbl (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(hist_q), .rd_ctr(gt_rd),
    .wr_en(gt_we), .wr_idx(u_hist), .wr_up(upd_taken),
    .wr_old(gt_old), .wr_new(gt_new)
  );

  tbp_counter_table #(.IDX_W(H_W), .CTR_W(C_CTR_W)) u_chooser (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(hist_q), .rd_ctr(ch_rd),
    .wr_en(ch_we), .wr_idx(u_hist), .wr_up(ch_up),
    .wr_old(ch_old), .wr_new(ch_new)
  );

  tbp_history #(.H_W(H_W)) u_hist_reg (
    .clk(clk), .rst_n(rst_n),
    .spec_en(pred_valid), .spec_bit(pred_taken),
    .fix_en(repair_ev), .fix_base(u_hist), .fix_bit(upd_taken),
    .hist(hist_q)
  );

  assign l_pred     = tbp_pkg::ctr_high(8'(lt_rd), L_CTR_W);
  assign g_pred     = tbp_pkg::ctr_high(8'(gt_rd), G_CTR_W);
  assign use_path   = tbp_pkg::ctr_high(8'(ch_rd), C_CTR_W);
  assign pred_taken = use_path ? g_pred : l_pred;
  assign pred_meta  = {hist_q, pred_taken, g_pred, l_pred};
endmodule

// File: rtl/tbp_checker.sv
`timescale 1ns/1ps
module tbp_checker #(
  parameter int unsigned L_CTR_W = 3,
  parameter int unsigned H_W     = 12,
  parameter int unsigned G_CTR_W = 2,
  parameter int unsigned C_CTR_W = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               pred_valid,
  input logic               pred_taken,
  input logic               upd_taken,
  input logic [H_W+2:0]     upd_meta,
  input logic [H_W-1:0]     hist_q,
  input logic               repair_ev,
  input logic               lt_we,
  input logic [L_CTR_W-1:0] lt_old,
  input logic [L_CTR_W-1:0] lt_new,
  input logic               gt_we,
  input logic [G_CTR_W-1:0] gt_old,
  input logic [G_CTR_W-1:0] gt_new,
  input logic               ch_we,
  input logic [C_CTR_W-1:0] ch_old,
  input logic [C_CTR_W-1:0] ch_new
);
  // R1
  hist_reset_chk: assert property (@(posedge clk) !rst_n |=> hist_q == '0);

  // R6
  hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_valid && !repair_ev) |=> hist_q == {$past(hist_q[H_W-2:0]), $past(pred_taken)});

  // R7
  hist_repair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    repair_ev |=> hist_q == {$past(upd_meta[H_W+1:3]), $past(upd_taken)});

  // R8
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pred_valid && !repair_ev) |=> $stable(hist_q));

  // R2
  pc_up_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lt_we && upd_taken) |-> (lt_new >= lt_old) && (lt_new - lt_old <= 1));

  // R2
  pc_dn_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lt_we && !upd_taken) |-> (lt_new <= lt_old) && (lt_old - lt_new <= 1));

  // R3
  path_up_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gt_we && upd_taken) |-> (gt_new >= gt_old) && (gt_new - gt_old <= 1));

  // R3
  path_dn_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gt_we && !upd_taken) |-> (gt_new <= gt_old) && (gt_old - gt_new <= 1));

  // R5
  chooser_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_we && (upd_meta[1] == upd_taken)) |-> ch_new >= ch_old);

  // R5
  chooser_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_we && (upd_meta[0] == upd_taken)) |-> ch_new <= ch_old);

  // R5
  chooser_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ch_we |-> upd_meta[0] != upd_meta[1]);
endmodule

bind tournament_predictor tbp_checker #(
  .L_CTR_W(L_CTR_W), .H_W(H_W), .G_CTR_W(G_CTR_W), .C_CTR_W(C_CTR_W)
) u_tbp_chk (
  .clk(clk), .rst_n(rst_n), .pred_valid(pred_valid), .pred_taken(pred_taken),
  .upd_taken(upd_taken), .upd_meta(upd_meta), .hist_q(hist_q),
  .repair_ev(repair_ev), .lt_we(lt_we), .lt_old(lt_old), .lt_new(lt_new),
  .gt_we(gt_we), .gt_old(gt_old), .gt_new(gt_new),
  .ch_we(ch_we), .ch_old(ch_old), .ch_new(ch_new)
);

// File: tb/tb_tournament_predictor.sv
`timescale 1ns/1ps
module tb_tournament_predictor;
  localparam int LW = 10;
  localparam int HW = 12;
  localparam int MW = HW + 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pred_valid = 1'b0;
  logic [LW-1:0] pred_pcw = '0;
  logic          pred_taken;
  logic [MW-1:0] pred_meta;
  logic          upd_valid = 1'b0;
  logic [LW-1:0] upd_pcw = '0;
  logic          upd_taken = 1'b0;
  logic [MW-1:0] upd_meta = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tournament_predictor dut (
    .clk(clk), .rst_n(rst_n), .pred_valid(pred_valid), .pred_pcw(pred_pcw),
    .pred_taken(pred_taken), .pred_meta(pred_meta), .upd_valid(upd_valid),
    .upd_pcw(upd_pcw), .upd_taken(upd_taken), .upd_meta(upd_meta)
  );

  // reference state, built from the requirements
  int mlt [1024];
  int mgt [4096];
  int mch [4096];
  logic [HW-1:0] mh;

  function automatic int bstep(int v, bit up, int top);
    if (up) return (v >= top) ? top : v + 1;
    return (v <= 0) ? 0 : v - 1;
  endfunction

  function automatic logic [MW-1:0] mmeta(logic [LW-1:0] pcw);
    logic l, g, f;
    l = (mlt[pcw] > 3);
    g = (mgt[mh] > 1);
    f = (mch[mh] > 1) ? g : l;
    return {mh, f, g, l};
  endfunction

  function automatic void mtrain(logic [LW-1:0] pcw, logic t, logic [MW-1:0] m);
    logic [HW-1:0] h;
    h = m[MW-1:3];
    mlt[pcw] = bstep(mlt[pcw], t, 7);
    mgt[h]   = bstep(mgt[h], t, 3);
    if (m[0] != m[1]) mch[h] = bstep(mch[h], m[1] == t, 3);
    if (m[2] != t) mh = {h[HW-2:0], t};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic peek(logic [LW-1:0] pcw, output logic [MW-1:0] m);
    logic [MW-1:0] e;
    @(negedge clk);
    pred_valid = 1'b0; pred_pcw = pcw;
    #1;
    e = mmeta(pcw);
    check("R9 meta", 32'(pred_meta), 32'(e));
    check("R4 pred", 32'(pred_taken), 32'(e[2]));
    m = pred_meta;
  endtask

  task automatic predict(logic [LW-1:0] pcw, output logic [MW-1:0] m);
    logic [MW-1:0] e;
    @(negedge clk);
    pred_valid = 1'b1; pred_pcw = pcw;
    #1;
    e = mmeta(pcw);
    check("R9 meta", 32'(pred_meta), 32'(e));
    check("R4 pred", 32'(pred_taken), 32'(e[2]));
    m = pred_meta;
    @(posedge clk); #1;
    pred_valid = 1'b0;
    mh = {mh[HW-2:0], e[2]};
  endtask

  task automatic update(logic [LW-1:0] pcw, logic t, logic [MW-1:0] m);
    @(negedge clk);
    upd_valid = 1'b1; upd_pcw = pcw; upd_taken = t; upd_meta = m;
    @(posedge clk); #1;
    upd_valid = 1'b0;
    mtrain(pcw, t, m);
  endtask

  // force the history to h through a deliberate repair (R7)
  task automatic set_hist(logic [HW-1:0] h);
    update(10'h3FF, h[0], {1'b0, h[HW-1:1], ~h[0], ~h[0], ~h[0]});
  endtask

  // stimulus vectors: {pc word, outcome}
  localparam logic [LW:0] VEC [16] = '{
    {10'h004, 1'b1}, {10'h004, 1'b1}, {10'h004, 1'b1}, {10'h004, 1'b1},
    {10'h009, 1'b0}, {10'h009, 1'b1}, {10'h004, 1'b0}, {10'h009, 1'b1},
    {10'h011, 1'b1}, {10'h011, 1'b0}, {10'h011, 1'b1}, {10'h011, 1'b1},
    {10'h004, 1'b1}, {10'h009, 1'b0}, {10'h011, 1'b1}, {10'h004, 1'b0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [MW-1:0] m, m2;
    logic [HW-1:0] h0;
    for (int i = 0; i < 1024; i++) mlt[i] = 3;
    for (int i = 0; i < 4096; i++) begin mgt[i] = 1; mch[i] = 1; end
    mh = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: reset state
    peek(10'h000, m);
    check("R1 meta after reset", 32'(m), 32'h0);
    check("R1 pred after reset", 32'(pred_taken), 32'h0);

    // vector walk: lookup then resolve each branch
    for (int i = 0; i < 16; i++) begin
      predict(VEC[i][LW:1], m);
      update(VEC[i][LW:1], VEC[i][0], m);
    end

    // R2: PC-table saturation at 7, threshold at 4
    for (int i = 0; i < 10; i++) update(10'h100, 1'b1, {12'h0AA, 3'b111});
    for (int i = 0; i < 3; i++)  update(10'h100, 1'b0, {12'h0AA, 3'b000});
    peek(10'h100, m);
    check("R2 ctr 4 taken", 32'(m[0]), 32'h1);
    update(10'h100, 1'b0, {12'h0AA, 3'b000});
    peek(10'h100, m);
    check("R2 ctr 3 not taken", 32'(m[0]), 32'h0);

    // R8: correct updates left the history alone
    h0 = m[MW-1:3];
    update(10'h101, 1'b1, {12'h123, 3'b111});
    peek(10'h101, m);
    check("R8 hist unchanged", 32'(m[MW-1:3]), 32'(h0));

    // R7: repair rebuilds from checkpoint
    set_hist(12'h5A5);
    peek(10'h120, m);
    check("R7 repaired hist", 32'(m[MW-1:3]), 32'h5A5);

    // R3: path-table saturation at 3
    for (int i = 0; i < 3; i++) update(10'h121, 1'b1, {12'h5A5, 3'b111});
    update(10'h121, 1'b0, {12'h5A5, 3'b000});
    peek(10'h120, m);
    check("R3 ctr 2 taken", 32'(m[1]), 32'h1);
    update(10'h121, 1'b0, {12'h5A5, 3'b000});
    peek(10'h120, m);
    check("R3 ctr 1 not taken", 32'(m[1]), 32'h0);

    // R5: chooser moves toward the correct component
    for (int i = 0; i < 2; i++) update(10'h121, 1'b1, {12'h5A5, 3'b111});
    peek(10'h130, m);
    check("R5 chooser favours PC table", 32'(pred_taken), 32'h0);
    update(10'h130, 1'b1, m);
    set_hist(12'h5A5);
    peek(10'h131, m);
    check("R5 chooser now favours path table", 32'(pred_taken), 32'h1);
    update(10'h132, 1'b0, {12'h5A5, 3'b011});
    peek(10'h131, m);
    check("R5 agreement leaves chooser", 32'(pred_taken), 32'h1);

    // R10: training goes to the metadata history, not the current one
    set_hist(12'h0F0);
    for (int i = 0; i < 2; i++) update(10'h140, 1'b1, {12'h333, 3'b111});
    set_hist(12'h333);
    peek(10'h141, m);
    check("R10 trained at checkpoint", 32'(m[1]), 32'h1);

    // R6: speculative shift
    peek(10'h004, m);
    h0 = m[MW-1:3];
    predict(10'h004, m);
    peek(10'h004, m2);
    check("R6 shifted hist", 32'(m2[MW-1:3]), 32'({h0[HW-2:0], m[2]}));

    // R7: repair wins over a same-cycle lookup
    set_hist(12'h800);
    @(negedge clk);
    pred_valid = 1'b1; pred_pcw = 10'h004;
    upd_valid = 1'b1; upd_pcw = 10'h150; upd_taken = 1'b1;
    upd_meta = {12'h456, 3'b000};
    @(posedge clk); #1;
    pred_valid = 1'b0; upd_valid = 1'b0;
    mtrain(10'h150, 1'b1, {12'h456, 3'b000});
    peek(10'h004, m);
    check("R7 repair beats lookup", 32'(m[MW-1:3]), 32'h8AD);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule